// File: doc/BRIEF.md
# CPU Register File with Byte/Pair Views and Shadow Bank

This block is the architectural register store of an 8-bit processor core. It holds four 16-bit working pairs (AF, BC, DE, HL) and a shadow copy of each. It also holds two 16-bit index registers that can be written by byte half, a 16-bit stack pointer, a 16-bit program counter, an 8-bit interrupt vector base, an 8-bit refresh counter, two interrupt-enable bits and a 2-bit interrupt-mode field. Instruction decode, the ALU and memory access live outside the block. They reach the registers through opcode-field selects.

Every working register can be read and written as a single byte or as part of a pair. Both views map onto the same storage, so a change made through one view shows in the other on the next cycle. Single-cycle exchange inputs swap AF with its shadow, swap BC/DE/HL with their shadows, or swap DE with HL. The flag byte can be updated under a bit mask. A refresh tick advances the low seven bits of the refresh counter.

Top module: `cpu_regfile`

## Requirements
- R1: While reset is low and in the first cycle after it, AF, BC, DE, HL, their shadows, IX and IY read 0xFFFF; SP reads 0xFFF0; PC reads 0x0000; I and R read 0xFF; both interrupt-enable bits and both mode bits read 0.
- R2: The byte select codes map as 000=B, 001=C, 010=D, 011=E, 100=H, 101=L, 111=A. In every pair the first-named register is bits 15:8 and the second-named is bits 7:0. A byte write shows through the pair read in the next cycle.
- R3: Byte select code 110 names no register. A read with it returns 0x00 and raises `byte_rd_bad`. A write with it raises `byte_wr_bad` in the same cycle and changes no register.
- R4: The pair select codes map as 00=BC, 01=DE, 10=HL, 11=SP. A pair write shows through the pair read and through both byte reads in the next cycle.
- R5: A refresh tick sets R[6:0] to (R[6:0]+1) mod 128 and leaves R[7] unchanged. A direct write to R in the same cycle takes priority over the tick.
- R6: A flag update sets each bit of F whose mask bit is 1 to the given value and leaves the other bits unchanged. Bit 0 is carry, bit 1 is subtract, and bit 2 is parity/overflow. The flag update is applied after any byte or pair write in the same cycle.
- R7: `xchg_af` swaps AF with AF' in one cycle and leaves the other pairs alone.
- R8: `xchg_all` swaps BC, DE and HL with their shadows in one cycle and leaves AF and AF' alone.
- R9: `xchg_dehl` swaps the active DE and HL in one cycle.
- R10: When several exchanges are requested in one cycle, they apply in this order: AF, then the full bank, then DE/HL. Byte, pair and flag writes in the same cycle land on the registers that are active after all the exchanges.
- R11: IX and IY are each written under two byte enables: bit 1 selects bits 15:8 and bit 0 selects bits 7:0. A disabled half keeps its value.
- R12: PC, I, the interrupt-enable bits and the mode bits load their write data in the cycle after their write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_rd_sel | input | 3 | Byte read select (opcode bits 5:3) |
| byte_rd_data | output | 8 | Selected byte |
| byte_rd_bad | output | 1 | Byte read select is the invalid code |
| byte_wr_en | input | 1 | Byte write enable |
| byte_wr_sel | input | 3 | Byte write select |
| byte_wr_data | input | 8 | Byte write data |
| byte_wr_bad | output | 1 | Byte write uses the invalid code |
| pair_rd_sel | input | 2 | Pair read select (opcode bits 5:4) |
| pair_rd_data | output | 16 | Selected pair |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_sel | input | 2 | Pair write select |
| pair_wr_data | input | 16 | Pair write data |
| af_q | output | 16 | Active accumulator/flag pair |
| flag_wr_mask | input | 8 | Flag bits to update |
| flag_wr_val | input | 8 | New flag values |
| xchg_af | input | 1 | Swap AF with its shadow |
| xchg_all | input | 1 | Swap BC/DE/HL with their shadows |
| xchg_dehl | input | 1 | Swap DE with HL |
| idx_wr_en | input | 1 | Index register write enable |
| idx_wr_sel | input | 1 | 0 = IX, 1 = IY |
| idx_wr_bytes | input | 2 | Byte enables: bit 1 high, bit 0 low |
| idx_wr_data | input | 16 | Index write data |
| ix_q | output | 16 | IX |
| iy_q | output | 16 | IY |
| pc_wr_en | input | 1 | PC write enable |
| pc_wr_data | input | 16 | PC write data |
| pc_q | output | 16 | PC |
| i_wr_en | input | 1 | Vector base write enable |
| i_wr_data | input | 8 | Vector base write data |
| i_q | output | 8 | Vector base |
| r_wr_en | input | 1 | Refresh register write enable |
| r_wr_data | input | 8 | Refresh register write data |
| refresh_tick | input | 1 | Advance refresh counter |
| r_q | output | 8 | Refresh register |
| iff_wr_en | input | 1 | Interrupt-enable write enable |
| iff_wr_data | input | 2 | Interrupt-enable bits |
| iff_q | output | 2 | Interrupt-enable bits |
| im_wr_en | input | 1 | Interrupt-mode write enable |
| im_wr_data | input | 2 | Interrupt-mode bits |
| im_q | output | 2 | Interrupt-mode bits |

## Verification
A corrupted working or shadow register shows up at the pair and byte read ports. For an active register this happens in the cycle after the bad write. For a shadow register it stays hidden until an exchange brings it forward, so exchanges are repeated and interleaved with writes to pull shadow contents back into view. A misplaced byte half or a wrong decode code shows as a byte/pair mismatch one cycle after the write. That is why every byte and pair select is swept on every cycle. A write ordered wrongly against an exchange leaves the data in the wrong bank, and it surfaces when the bank is swapped back.

// File: rtl/rf_pkg.sv
`timescale 1ns/10ps
package rf_pkg;
  localparam int unsigned RF_DW = 8;
  localparam int unsigned RF_PW = 2 * RF_DW;

  typedef logic [RF_DW-1:0] byte_t;
  typedef logic [RF_PW-1:0] pair_t;

  typedef enum logic [1:0] {
    PID_AF = 2'd0,
    PID_BC = 2'd1,
    PID_DE = 2'd2,
    PID_HL = 2'd3
  } pair_id_e;

  typedef struct packed {
    logic     valid;
    pair_id_e pair;
    logic     hi;
  } byte_loc_t;

  localparam pair_t RST_PAIR = '1;
  localparam pair_t RST_SP   = {{(RF_PW-4){1'b1}}, 4'h0};
  localparam pair_t RST_PC   = '0;
  localparam byte_t RST_IR   = '1;

  // opcode field -> storage location of a byte register
  function automatic byte_loc_t decode_byte(input logic [2:0] code);
    byte_loc_t loc;
    loc.valid = 1'b1;
    case (code)
      3'b111: begin loc.pair = PID_AF; loc.hi = 1'b1; end
      3'b110: begin loc.pair = PID_AF; loc.hi = 1'b1; loc.valid = 1'b0; end
      default: begin
        loc.pair = pair_id_e'(code[2:1] + 2'd1);
        loc.hi   = ~code[0];
      end
    endcase
    return loc;
  endfunction

  // seven-bit wrap, top bit preserved
  function automatic byte_t refresh_next(input byte_t r);
    return {r[RF_DW-1], r[RF_DW-2:0] + 1'b1};
  endfunction

  function automatic byte_t flag_merge(input byte_t f, input byte_t mask, input byte_t val);
    return (f & ~mask) | (val & mask);
  endfunction
endpackage

// File: rtl/rf_byte_decode.sv
`timescale 1ns/10ps
module rf_byte_decode
  import rf_pkg::*;
(
  input  logic [2:0] code,
  output byte_loc_t  loc
);
  assign loc = decode_byte(code);
endmodule

// File: rtl/rf_index_reg.sv
`timescale 1ns/10ps
module rf_index_reg
  import rf_pkg::*;
#(
  parameter pair_t RESET_VAL = RST_PAIR
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hi,
  input  logic  wr_lo,
  input  pair_t wr_data,
  output pair_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RESET_VAL;
    end else begin
      if (wr_hi) q[RF_PW-1:RF_DW] <= wr_data[RF_PW-1:RF_DW];
      if (wr_lo) q[RF_DW-1:0]     <= wr_data[RF_DW-1:0];
    end
  end
endmodule

// File: rtl/rf_pair_bank.sv
`timescale 1ns/10ps
module rf_pair_bank
  import rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xchg_af,
  input  logic          xchg_all,
  input  logic          xchg_dehl,
  input  logic          bwr_en,
  input  byte_loc_t     bwr_loc,
  input  byte_t         bwr_data,
  input  logic          pwr_en,
  input  pair_id_e      pwr_id,
  input  pair_t         pwr_data,
  input  byte_t         flag_mask,
  input  byte_t         flag_val,
  output pair_t [3:0]   act_q,
  output pair_t [3:0]   shd_q
);
  pair_t [3:0] nxt_act;
  pair_t [3:0] nxt_shd;
  pair_t       tmp;

  always_comb begin
    nxt_act = act_q;
    nxt_shd = shd_q;
    tmp     = '0;
    // exchanges first, in fixed order
    if (xchg_af) begin
      nxt_act[PID_AF] = shd_q[PID_AF];
      nxt_shd[PID_AF] = act_q[PID_AF];
    end
    if (xchg_all) begin
      for (int k = 1; k < 4; k++) begin
        nxt_act[k] = shd_q[k];
        nxt_shd[k] = act_q[k];
      end
    end
    if (xchg_dehl) begin
      tmp             = nxt_act[PID_DE];
      nxt_act[PID_DE] = nxt_act[PID_HL];
      nxt_act[PID_HL] = tmp;
    end
    // writes land on the post-exchange registers
    if (bwr_en) begin
      if (bwr_loc.hi) nxt_act[bwr_loc.pair][RF_PW-1:RF_DW] = bwr_data;
      else            nxt_act[bwr_loc.pair][RF_DW-1:0]     = bwr_data;
    end
    if (pwr_en) nxt_act[pwr_id] = pwr_data;
    nxt_act[PID_AF][RF_DW-1:0] = flag_merge(nxt_act[PID_AF][RF_DW-1:0], flag_mask, flag_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= {4{RST_PAIR}};
      shd_q <= {4{RST_PAIR}};
    end else begin
      act_q <= nxt_act;
      shd_q <= nxt_shd;
    end
  end
endmodule

// File: rtl/cpu_regfile.sv
`timescale 1ns/10ps
module cpu_regfile
  import rf_pkg::*;
#(
  parameter int unsigned N_IDX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       byte_rd_sel,
  output logic [RF_DW-1:0] byte_rd_data,
  output logic             byte_rd_bad,
  input  logic             byte_wr_en,
  input  logic [2:0]       byte_wr_sel,
  input  logic [RF_DW-1:0] byte_wr_data,
  output logic             byte_wr_bad,
  input  logic [1:0]       pair_rd_sel,
  output logic [RF_PW-1:0] pair_rd_data,
  input  logic             pair_wr_en,
  input  logic [1:0]       pair_wr_sel,
  input  logic [RF_PW-1:0] pair_wr_data,
  output logic [RF_PW-1:0] af_q,
  input  logic [RF_DW-1:0] flag_wr_mask,
  input  logic [RF_DW-1:0] flag_wr_val,
  input  logic             xchg_af,
  input  logic             xchg_all,
  input  logic             xchg_dehl,
  input  logic             idx_wr_en,
  input  logic             idx_wr_sel,
  input  logic [1:0]       idx_wr_bytes,
  input  logic [RF_PW-1:0] idx_wr_data,
  output logic [RF_PW-1:0] ix_q,
  output logic [RF_PW-1:0] iy_q,
  input  logic             pc_wr_en,
  input  logic [RF_PW-1:0] pc_wr_data,
  output logic [RF_PW-1:0] pc_q,
  input  logic             i_wr_en,
  input  logic [RF_DW-1:0] i_wr_data,
  output logic [RF_DW-1:0] i_q,
  input  logic             r_wr_en,
  input  logic [RF_DW-1:0] r_wr_data,
  input  logic             refresh_tick,
  output logic [RF_DW-1:0] r_q,
  input  logic             iff_wr_en,
  input  logic [1:0]       iff_wr_data,
  output logic [1:0]       iff_q,
  input  logic             im_wr_en,
  input  logic [1:0]       im_wr_data,
  output logic [1:0]       im_q
);
  localparam logic [1:0] SP_CODE = 2'b11;

  byte_loc_t   rd_loc, wr_loc;
  pair_t [3:0] act_q, shd_q;
  pair_t       rd_word, sp_q;
  pair_t       idx_q [N_IDX];
  logic        bwr_ok, pwr_bank;

  // named views for the checker
  pair_t act_af, act_bc, act_de, act_hl;
  pair_t shd_af, shd_bc, shd_de, shd_hl;
  assign act_af = act_q[PID_AF];
  assign act_bc = act_q[PID_BC];
  assign act_de = act_q[PID_DE];
  assign act_hl = act_q[PID_HL];
  assign shd_af = shd_q[PID_AF];
  assign shd_bc = shd_q[PID_BC];
  assign shd_de = shd_q[PID_DE];
  assign shd_hl = shd_q[PID_HL];

  rf_byte_decode u_rd_dec (.code(byte_rd_sel), .loc(rd_loc));
  rf_byte_decode u_wr_dec (.code(byte_wr_sel), .loc(wr_loc));

  assign bwr_ok   = byte_wr_en & wr_loc.valid;
  assign pwr_bank = pair_wr_en & (pair_wr_sel != SP_CODE);

  rf_pair_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .xchg_af   (xchg_af),
    .xchg_all  (xchg_all),
    .xchg_dehl (xchg_dehl),
    .bwr_en    (bwr_ok),
    .bwr_loc   (wr_loc),
    .bwr_data  (byte_wr_data),
    .pwr_en    (pwr_bank),
    .pwr_id    (pair_id_e'(pair_wr_sel + 2'd1)),
    .pwr_data  (pair_wr_data),
    .flag_mask (flag_wr_mask),
    .flag_val  (flag_wr_val),
    .act_q     (act_q),
    .shd_q     (shd_q)
  );

  // read muxes
  assign rd_word      = act_q[rd_loc.pair];
  assign byte_rd_bad  = ~rd_loc.valid;
  assign byte_rd_data = !rd_loc.valid ? '0 :
                        (rd_loc.hi ? rd_word[RF_PW-1:RF_DW] : rd_word[RF_DW-1:0]);
  assign byte_wr_bad  = byte_wr_en & ~wr_loc.valid;
  assign pair_rd_data = (pair_rd_sel == SP_CODE) ? sp_q
                                                 : act_q[pair_id_e'(pair_rd_sel + 2'd1)];
  assign af_q         = act_af;

  // index registers
  for (genvar g = 0; g < N_IDX; g++) begin : g_idx
    logic sel_g;
    assign sel_g = idx_wr_en && (idx_wr_sel == 1'(g));
    rf_index_reg u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (sel_g & idx_wr_bytes[1]),
      .wr_lo   (sel_g & idx_wr_bytes[0]),
      .wr_data (idx_wr_data),
      .q       (idx_q[g])
    );
  end
  assign ix_q = idx_q[0];
  assign iy_q = idx_q[1];

  // special registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= RST_SP;
      pc_q  <= RST_PC;
      i_q   <= RST_IR;
      r_q   <= RST_IR;
      iff_q <= '0;
      im_q  <= '0;
    end else begin
      if (pair_wr_en && pair_wr_sel == SP_CODE) sp_q <= pair_wr_data;
      if (pc_wr_en)  pc_q  <= pc_wr_data;
      if (i_wr_en)   i_q   <= i_wr_data;
      if (iff_wr_en) iff_q <= iff_wr_data;
      if (im_wr_en)  im_q  <= im_wr_data;
      if (r_wr_en)           r_q <= r_wr_data;
      else if (refresh_tick) r_q <= refresh_next(r_q);
    end
  end
endmodule

// File: rtl/cpu_regfile_chk.sv
`timescale 1ns/10ps
module cpu_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xchg_af,
  input logic        xchg_all,
  input logic        xchg_dehl,
  input logic        byte_wr_en,
  input logic        byte_wr_bad,
  input logic [2:0]  byte_rd_sel,
  input logic        byte_rd_bad,
  input logic        pair_wr_en,
  input logic [1:0]  pair_wr_sel,
  input logic [15:0] pair_wr_data,
  input logic [7:0]  flag_wr_mask,
  input logic        refresh_tick,
  input logic        r_wr_en,
  input logic [7:0]  r_q,
  input logic [15:0] act_af,
  input logic [15:0] act_bc,
  input logic [15:0] act_de,
  input logic [15:0] act_hl,
  input logic [15:0] shd_af,
  input logic [15:0] shd_bc,
  input logic [15:0] shd_de,
  input logic [15:0] shd_hl
);
  logic quiet_wr;
  assign quiet_wr = !byte_wr_en && !pair_wr_en && (flag_wr_mask == 8'h00);

  a_r3_bad_read_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd_sel == 3'b110 |-> byte_rd_bad);

  a_r3_bad_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr_bad && !pair_wr_en && flag_wr_mask == 8'h00 && !xchg_af && !xchg_all && !xchg_dehl
    |=> act_af == $past(act_af) && act_bc == $past(act_bc) &&
        act_de == $past(act_de) && act_hl == $past(act_hl));

  a_r4_pair_into_bc: assert property (@(posedge clk) disable iff (!rst_n)
    pair_wr_en && pair_wr_sel == 2'b00 && !xchg_all && !byte_wr_en
    |=> act_bc == $past(pair_wr_data));

  a_r5_refresh_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_tick && !r_wr_en
    |=> r_q[7] == $past(r_q[7]) && r_q[6:0] == 7'($past(r_q[6:0]) + 7'd1));

  a_r6_masked_bits_only: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_wr_en && !pair_wr_en && !xchg_af
    |=> ((act_af[7:0] ^ $past(act_af[7:0])) & ~$past(flag_wr_mask)) == 8'h00);

  a_r7_af_swap: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_af && quiet_wr
    |=> act_af == $past(shd_af) && shd_af == $past(act_af));

  a_r8_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_all && !xchg_af && !xchg_dehl && quiet_wr
    |=> act_bc == $past(shd_bc) && shd_bc == $past(act_bc) &&
        act_de == $past(shd_de) && shd_hl == $past(act_hl) &&
        act_af == $past(act_af) && shd_af == $past(shd_af));

  a_r9_dehl_swap: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_dehl && !xchg_all && quiet_wr
    |=> act_de == $past(act_hl) && act_hl == $past(act_de));
endmodule

bind cpu_regfile cpu_regfile_chk u_chk (.*);

// File: tb/tb_cpu_regfile.sv
`timescale 1ns/10ps
module tb_cpu_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]  byte_rd_sel;  logic [7:0] byte_rd_data; logic byte_rd_bad;
  logic        byte_wr_en;   logic [2:0] byte_wr_sel;  logic [7:0] byte_wr_data; logic byte_wr_bad;
  logic [1:0]  pair_rd_sel;  logic [15:0] pair_rd_data;
  logic        pair_wr_en;   logic [1:0] pair_wr_sel;  logic [15:0] pair_wr_data;
  logic [15:0] af_q;
  logic [7:0]  flag_wr_mask, flag_wr_val;
  logic        xchg_af, xchg_all, xchg_dehl;
  logic        idx_wr_en, idx_wr_sel; logic [1:0] idx_wr_bytes; logic [15:0] idx_wr_data;
  logic [15:0] ix_q, iy_q;
  logic        pc_wr_en; logic [15:0] pc_wr_data, pc_q;
  logic        i_wr_en;  logic [7:0] i_wr_data, i_q;
  logic        r_wr_en;  logic [7:0] r_wr_data; logic refresh_tick; logic [7:0] r_q;
  logic        iff_wr_en; logic [1:0] iff_wr_data, iff_q;
  logic        im_wr_en;  logic [1:0] im_wr_data, im_q;

  cpu_regfile dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state: index 0..7 = A F B C D E H L
  logic [7:0]  ma [8];
  logic [7:0]  ms [8];
  logic [15:0] msp, mpc, mix, miy;
  logic [7:0]  mi, mr;
  logic [1:0]  miff, mim;

  function automatic int code_to_slot(logic [2:0] c);
    case (c)
      3'd0: return 2;  3'd1: return 3;  3'd2: return 4;  3'd3: return 5;
      3'd4: return 6;  3'd5: return 7;  3'd7: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 8; k++) begin ma[k] = 8'hFF; ms[k] = 8'hFF; end
    msp = 16'hFFF0; mpc = 16'h0000; mix = 16'hFFFF; miy = 16'hFFFF;
    mi = 8'hFF; mr = 8'hFF; miff = 2'b00; mim = 2'b00;
  endtask

  task automatic swap_slots(ref logic [7:0] x [8], ref logic [7:0] y [8], input int a, input int b);
    logic [7:0] t;
    t = x[a]; x[a] = y[b]; y[b] = t;
  endtask

  task automatic m_step();
    int p;
    if (!rst_n) begin m_reset(); return; end
    if (xchg_af) for (int k = 0; k < 2; k++) swap_slots(ma, ms, k, k);
    if (xchg_all) for (int k = 2; k < 8; k++) swap_slots(ma, ms, k, k);
    if (xchg_dehl) begin swap_slots(ma, ma, 4, 6); swap_slots(ma, ma, 5, 7); end
    p = code_to_slot(byte_wr_sel);
    if (byte_wr_en && p >= 0) ma[p] = byte_wr_data;
    if (pair_wr_en) begin
      if (pair_wr_sel == 2'd3) msp = pair_wr_data;
      else begin
        ma[2 + 2*pair_wr_sel] = pair_wr_data[15:8];
        ma[3 + 2*pair_wr_sel] = pair_wr_data[7:0];
      end
    end
    for (int b = 0; b < 8; b++) if (flag_wr_mask[b]) ma[1][b] = flag_wr_val[b];
    if (idx_wr_en) begin
      if (idx_wr_sel == 1'b0) begin
        if (idx_wr_bytes[1]) mix[15:8] = idx_wr_data[15:8];
        if (idx_wr_bytes[0]) mix[7:0]  = idx_wr_data[7:0];
      end else begin
        if (idx_wr_bytes[1]) miy[15:8] = idx_wr_data[15:8];
        if (idx_wr_bytes[0]) miy[7:0]  = idx_wr_data[7:0];
      end
    end
    if (r_wr_en) mr = r_wr_data;
    else if (refresh_tick) mr = 8'((mr & 8'h80) | ((int'(mr) + 1) % 128));
    if (pc_wr_en)  mpc  = pc_wr_data;
    if (i_wr_en)   mi   = i_wr_data;
    if (iff_wr_en) miff = iff_wr_data;
    if (im_wr_en)  mim  = im_wr_data;
  endtask

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int s = 0; s < 8; s++) begin
      int p;
      byte_rd_sel = 3'(s); #0.1;
      p = code_to_slot(3'(s));
      chk(tag, $sformatf("byte read code %0d", s), {7'd0, byte_rd_bad, byte_rd_data},
          (p < 0) ? 16'h0100 : {8'h00, ma[p]});
    end
    for (int s = 0; s < 4; s++) begin
      pair_rd_sel = 2'(s); #0.1;
      chk(tag, $sformatf("pair read code %0d", s), pair_rd_data,
          (s == 3) ? msp : {ma[2+2*s], ma[3+2*s]});
    end
    chk(tag, "af", af_q, {ma[0], ma[1]});
    chk(tag, "byte_wr_bad", {15'd0, byte_wr_bad}, {15'd0, byte_wr_en && byte_wr_sel == 3'b110});
    chk(tag, "ix", ix_q, mix);
    chk(tag, "iy", iy_q, miy);
    chk(tag, "pc", pc_q, mpc);
    chk(tag, "i/r", {i_q, r_q}, {mi, mr});
    chk(tag, "iff/im", {12'd0, iff_q, im_q}, {12'd0, miff, mim});
  endtask

  task automatic clr();
    byte_rd_sel = 0; byte_wr_en = 0; byte_wr_sel = 0; byte_wr_data = 0;
    pair_rd_sel = 0; pair_wr_en = 0; pair_wr_sel = 0; pair_wr_data = 0;
    flag_wr_mask = 0; flag_wr_val = 0; xchg_af = 0; xchg_all = 0; xchg_dehl = 0;
    idx_wr_en = 0; idx_wr_sel = 0; idx_wr_bytes = 0; idx_wr_data = 0;
    pc_wr_en = 0; pc_wr_data = 0; i_wr_en = 0; i_wr_data = 0;
    r_wr_en = 0; r_wr_data = 0; refresh_tick = 0;
    iff_wr_en = 0; iff_wr_data = 0; im_wr_en = 0; im_wr_data = 0;
  endtask

  // called just after a falling edge with inputs set
  task automatic cyc(string tag);
    #0.1;
    compare(tag);
    @(posedge clk);
    m_step();
    @(negedge clk);
    clr();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    clr();
    m_reset();
    repeat (3) @(negedge clk);
    cyc("R1");
    rst_n = 1'b1;
    cyc("R1");

    // R2: write each byte code, read back both views
    for (int c = 0; c < 8; c++) begin
      if (c == 6) continue;
      byte_wr_en = 1; byte_wr_sel = 3'(c); byte_wr_data = 8'(8'h11 * (c + 1));
      cyc("R2");
    end
    cyc("R2");
    // R3: invalid code write, then observe
    byte_wr_en = 1; byte_wr_sel = 3'b110; byte_wr_data = 8'h5A;
    cyc("R3");
    cyc("R3");
    // R4: pair writes, including SP
    for (int c = 0; c < 4; c++) begin
      pair_wr_en = 1; pair_wr_sel = 2'(c); pair_wr_data = 16'(16'hA1B2 + 16'h1111 * c);
      cyc("R4");
    end
    byte_wr_en = 1; byte_wr_sel = 3'd5; byte_wr_data = 8'hC3;
    cyc("R4");
    cyc("R4");
    // R5: refresh ticks across the 7-bit wrap, plus write priority
    for (int n = 0; n < 130; n++) begin refresh_tick = 1; cyc("R5"); end
    r_wr_en = 1; r_wr_data = 8'h7F; refresh_tick = 1; cyc("R5");
    refresh_tick = 1; cyc("R5");
    refresh_tick = 1; cyc("R5");
    // R6: masked flag updates
    flag_wr_mask = 8'h01; flag_wr_val = 8'h00; cyc("R6");
    flag_wr_mask = 8'h06; flag_wr_val = 8'hFF; cyc("R6");
    flag_wr_mask = 8'hF0; flag_wr_val = 8'h5A; cyc("R6");
    byte_wr_en = 1; byte_wr_sel = 3'd7; byte_wr_data = 8'h3C;
    flag_wr_mask = 8'hFF; flag_wr_val = 8'h81; cyc("R6");
    pair_wr_en = 1; pair_wr_sel = 2'd0; pair_wr_data = 16'h0F0F;
    flag_wr_mask = 8'h00; cyc("R6");
    // R7: AF exchange
    xchg_af = 1; cyc("R7");
    cyc("R7");
    flag_wr_mask = 8'hFF; flag_wr_val = 8'h42; cyc("R7");
    xchg_af = 1; cyc("R7");
    xchg_af = 1; cyc("R7");
    // R8: full-bank exchange
    xchg_all = 1; cyc("R8");
    pair_wr_en = 1; pair_wr_sel = 2'd1; pair_wr_data = 16'hDEAD; cyc("R8");
    byte_wr_en = 1; byte_wr_sel = 3'd4; byte_wr_data = 8'h99; cyc("R8");
    xchg_all = 1; cyc("R8");
    xchg_all = 1; cyc("R8");
    // R9: DE/HL exchange
    xchg_dehl = 1; cyc("R9");
    xchg_dehl = 1; cyc("R9");
    xchg_dehl = 1; cyc("R9");
    // R10: writes colliding with exchanges
    xchg_all = 1; pair_wr_en = 1; pair_wr_sel = 2'd2; pair_wr_data = 16'hBEEF; cyc("R10");
    xchg_all = 1; cyc("R10");
    xchg_af = 1; xchg_all = 1; xchg_dehl = 1;
    byte_wr_en = 1; byte_wr_sel = 3'd2; byte_wr_data = 8'h77; flag_wr_mask = 8'h0F; flag_wr_val = 8'h0A;
    cyc("R10");
    xchg_af = 1; xchg_all = 1; cyc("R10");
    // R11: index byte halves
    idx_wr_en = 1; idx_wr_sel = 0; idx_wr_bytes = 2'b01; idx_wr_data = 16'h1234; cyc("R11");
    idx_wr_en = 1; idx_wr_sel = 1; idx_wr_bytes = 2'b10; idx_wr_data = 16'h5678; cyc("R11");
    idx_wr_en = 1; idx_wr_sel = 0; idx_wr_bytes = 2'b11; idx_wr_data = 16'h9ABC; cyc("R11");
    idx_wr_en = 1; idx_wr_sel = 1; idx_wr_bytes = 2'b00; idx_wr_data = 16'h0000; cyc("R11");
    // R12: PC, I, interrupt bits
    pc_wr_en = 1; pc_wr_data = 16'h8000; i_wr_en = 1; i_wr_data = 8'h3E; cyc("R12");
    iff_wr_en = 1; iff_wr_data = 2'b11; im_wr_en = 1; im_wr_data = 2'b10; cyc("R12");
    iff_wr_en = 1; iff_wr_data = 2'b01; cyc("R12");
    cyc("R12");
    // R10: randomized mix of writes and exchanges
    for (int n = 0; n < 400; n++) begin
      byte_wr_en   = 1'($urandom_range(0, 1));
      byte_wr_sel  = 3'($urandom);
      byte_wr_data = 8'($urandom);
      pair_wr_en   = ($urandom_range(0, 3) == 0);
      pair_wr_sel  = 2'($urandom);
      pair_wr_data = 16'($urandom);
      flag_wr_mask = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      flag_wr_val  = 8'($urandom);
      xchg_af      = ($urandom_range(0, 3) == 0);
      xchg_all     = ($urandom_range(0, 3) == 0);
      xchg_dehl    = ($urandom_range(0, 3) == 0);
      idx_wr_en    = ($urandom_range(0, 3) == 0);
      idx_wr_sel   = 1'($urandom);
      idx_wr_bytes = 2'($urandom);
      idx_wr_data  = 16'($urandom);
      refresh_tick = 1'($urandom);
      r_wr_en      = ($urandom_range(0, 7) == 0);
      r_wr_data    = 8'($urandom);
      pc_wr_en     = ($urandom_range(0, 3) == 0);
      pc_wr_data   = 16'($urandom);
      cyc("R10");
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule